// File: doc/BRIEF.md
# Level-Probing IO Translation Cache

This block is a small, fully associative cache of finished address translations for an IO memory-management unit. Each stored translation carries an address-space identifier, an input address aligned to its block, a granule code, the table level it was found at, an aligned output address and a two-bit permission field. The block size of an entry is implied by its granule and level and is never stored.

A lookup gives an identifier, an input address, a granule code and the table size field `tsz`. The block computes the first table level that this configuration can use. It then probes one level per clock, masking the input address to that level's block size, until an entry matches or level 3 has been tried. A separate command port inserts translations and removes them: all of them, all of one identifier, or those that overlap an address range. Two saturating counters record hits and misses.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous reset the cache holds no valid entry, `lk_busy` and `rsp_valid` are 0, and both counters read 0.
- R2: Granule codes 1, 2 and 3 select 4 KB, 16 KB and 64 KB pages (granule log2 = 10 + 2·code). The first probed level is 4 − (60 − tsz) / (granule log2 − 3). A lookup accepted at one clock edge probes one level per edge, moving toward level 3. Its result appears as a one-cycle `rsp_valid` pulse exactly n edges later, where n is the number of levels probed. `lk_busy` stays high until that result.
- R3: At level L the block shift is (granule log2 − 3)·(4 − L) + 3. A probe hits an entry only when the identifier, granule code and level are equal and the input address with its low shift bits cleared equals the entry address. A hit returns `rsp_hit`=1, `rsp_oaddr` = entry output | (input address & block mask), the entry's permission and the level.
- R4: When no level hits, the result has `rsp_hit`=0, `rsp_oaddr`=0 and `rsp_perm`=0.
- R5: Insert (`cmd_op`=0) takes its block size from `cmd_level` and `cmd_gcode`, and stores both addresses with the bits below that block cleared. If an entry with the same identifier, granule, level and aligned address exists, it is overwritten. Otherwise the lowest free slot is used.
- R6: Insert into a cache whose slots are all valid first invalidates every entry, then writes the new one, which leaves exactly one valid entry.
- R7: Invalidate-all (`cmd_op`=1) clears every entry.
- R8: Invalidate-by-identifier (`cmd_op`=2) clears exactly the entries whose identifier equals `cmd_asid`.
- R9: Range invalidation (`cmd_op`=3) uses granule log2 = 12 when `cmd_gcode`=0, and range mask = (`cmd_npages` << granule log2) − 1. An entry is removed when its identifier matches, or `cmd_any_asid`=1, and either of two conditions holds: the command address with the entry's block bits cleared equals the entry address, or the entry address with the range-mask bits cleared equals the command address.
- R10: When a range invalidation has `cmd_level`≠0, `cmd_npages`=1 and `cmd_any_asid`=0, it first removes only the entry whose identifier, address, granule code and level equal the command's fields exactly. If no such entry exists, the rule of R9 applies.
- R11: `hit_count` and `miss_count` each rise by one when a hit or miss result is produced, in the same cycle as `rsp_valid`, and stop at their all-ones value.
- R12: A lookup request presented while `lk_busy` is 1 is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_addr | input | IA_W | Lookup input address |
| lk_gcode | input | 2 | Lookup granule code |
| lk_tsz | input | 6 | Table size field (16..39) |
| lk_busy | output | 1 | Lookup in progress |
| rsp_valid | output | 1 | Result pulse |
| rsp_hit | output | 1 | Result was a hit |
| rsp_oaddr | output | OA_W | Translated address |
| rsp_perm | output | 2 | Permission of the hit entry |
| rsp_level | output | 2 | Level of the last probe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 insert, 1 inv all, 2 inv id, 3 inv range |
| cmd_asid | input | ASID_W | Command identifier |
| cmd_any_asid | input | 1 | Range invalidation matches every identifier |
| cmd_addr | input | IA_W | Command address |
| cmd_gcode | input | 2 | Command granule code |
| cmd_level | input | 2 | Insert level / range level hint (0 = none) |
| cmd_npages | input | NP_W | Range length in pages |
| cmd_oaddr | input | OA_W | Insert output address |
| cmd_perm | input | 2 | Insert permission |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The hardest case to reach is the insert that finds every slot occupied, because sixteen distinct valid tags must first be built up through the port. The bench inserts sixteen pages for one identifier, confirms that one of them hits, and then inserts a seventeenth page. After that, the older page misses and only the new page hits. The exact-tag path of a single-page range invalidation is also hard to observe. The bench places a 4 KB page inside a 2 MB block. An exact removal of the block leaves the page in place, whereas a range removal would have cleared both.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  typedef enum logic [1:0] {
    OP_INSERT    = 2'd0,
    OP_INV_ALL   = 2'd1,
    OP_INV_ASID  = 2'd2,
    OP_INV_RANGE = 2'd3
  } cmd_op_e;

  // log2 of the page size; code 0 is taken as 4 KB
  function automatic logic [5:0] gran_log2(input logic [1:0] gc);
    int g;
    g = (gc == 2'd0) ? 12 : 10 + 2 * int'(gc);
    return 6'(g);
  endfunction

  function automatic logic [5:0] lvl_shift(input logic [1:0] lvl, input logic [1:0] gc);
    int g;
    int sh;
    g  = int'(gran_log2(gc));
    sh = (g - 3) * (4 - int'(lvl)) + 3;
    return 6'(sh);
  endfunction

  function automatic logic [63:0] blk_mask64(input logic [1:0] lvl, input logic [1:0] gc);
    return (64'd1 << lvl_shift(lvl, gc)) - 64'd1;
  endfunction

  function automatic logic [1:0] start_level(input logic [5:0] tsz, input logic [1:0] gc);
    int insz;
    int q;
    insz = 64 - int'(tsz);
    case (gc)
      2'd2:    q = (insz - 4) / 11;
      2'd3:    q = (insz - 4) / 13;
      default: q = (insz - 4) / 9;
    endcase
    if (q > 4) q = 4;
    if (q < 1) q = 1;
    return 2'(4 - q);
  endfunction

endpackage

// File: rtl/xlat_sat_counter.sv
module xlat_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && (cnt != {W{1'b1}})) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/xlat_cache_store.sv
module xlat_cache_store
  import xlat_cache_pkg::*;
#(
  parameter int N      = 16,
  parameter int ASID_W = 16,
  parameter int IA_W   = 48,
  parameter int OA_W   = 48,
  parameter int NP_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_any_asid,
  input  logic [IA_W-1:0]   cmd_addr,
  input  logic [1:0]        cmd_gcode,
  input  logic [1:0]        cmd_level,
  input  logic [NP_W-1:0]   cmd_npages,
  input  logic [OA_W-1:0]   cmd_oaddr,
  input  logic [1:0]        cmd_perm,
  output logic [N-1:0]      e_vld,
  output logic [ASID_W-1:0] e_asid  [N],
  output logic [IA_W-1:0]   e_addr  [N],
  output logic [1:0]        e_gc    [N],
  output logic [1:0]        e_lvl   [N],
  output logic [OA_W-1:0]   e_oaddr [N],
  output logic [1:0]        e_perm  [N]
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  cmd_op_e            op;
  logic [IA_W-1:0]    ins_mask;
  logic [IA_W-1:0]    ins_addr;
  logic [IA_W-1:0]    rmask;
  logic [N-1:0]       tag_eq, exact_eq, asid_eq, range_hit;
  logic [IDX_W-1:0]   free_idx, dup_idx, wr_idx;
  logic               full, exact_try, wr_en;
  logic [N-1:0]       kill, vld_nx;

  assign op        = cmd_op_e'(cmd_op);
  assign ins_mask  = IA_W'(blk_mask64(cmd_level, cmd_gcode));
  assign ins_addr  = cmd_addr & ~ins_mask;
  assign rmask     = IA_W'((64'(cmd_npages) << gran_log2(cmd_gcode)) - 64'd1);
  assign full      = &e_vld;
  assign exact_try = (cmd_level != 2'd0) && (cmd_npages == NP_W'(1)) && !cmd_any_asid;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [IA_W-1:0] emask;
    logic            id_eq;
    assign emask        = IA_W'(blk_mask64(e_lvl[i], e_gc[i]));
    assign id_eq        = e_vld[i] && (e_asid[i] == cmd_asid);
    assign asid_eq[i]   = id_eq;
    assign tag_eq[i]    = id_eq && (e_gc[i] == cmd_gcode) && (e_lvl[i] == cmd_level)
                          && (e_addr[i] == ins_addr);
    assign exact_eq[i]  = id_eq && (e_gc[i] == cmd_gcode) && (e_lvl[i] == cmd_level)
                          && (e_addr[i] == cmd_addr);
    assign range_hit[i] = e_vld[i] && (cmd_any_asid || id_eq)
                          && (((cmd_addr & ~emask) == e_addr[i])
                              || ((e_addr[i] & ~rmask) == cmd_addr));
  end

  always_comb begin
    free_idx = '0;
    dup_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!e_vld[i]) free_idx = IDX_W'(i);
      if (tag_eq[i]) dup_idx  = IDX_W'(i);
    end
  end

  always_comb begin
    kill   = '0;
    wr_en  = 1'b0;
    wr_idx = free_idx;
    if (cmd_valid) begin
      case (op)
        OP_INSERT: begin
          wr_en = 1'b1;
          if (full) begin
            kill   = '1;
            wr_idx = '0;
          end else if (|tag_eq) begin
            wr_idx = dup_idx;
          end
        end
        OP_INV_ALL:   kill = '1;
        OP_INV_ASID:  kill = asid_eq;
        OP_INV_RANGE: kill = (exact_try && |exact_eq) ? exact_eq : range_hit;
        default:      kill = '0;
      endcase
    end
    vld_nx = e_vld & ~kill;
    if (wr_en) vld_nx[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) e_vld <= '0;
    else     e_vld <= vld_nx;
  end

  // payload arrays carry no reset; validity is held in e_vld
  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_asid[wr_idx]  <= cmd_asid;
      e_addr[wr_idx]  <= ins_addr;
      e_gc[wr_idx]    <= cmd_gcode;
      e_lvl[wr_idx]   <= cmd_level;
      e_oaddr[wr_idx] <= cmd_oaddr & ~OA_W'(ins_mask);
      e_perm[wr_idx]  <= cmd_perm;
    end
  end
endmodule

// File: rtl/xlat_cache_probe.sv
module xlat_cache_probe
  import xlat_cache_pkg::*;
#(
  parameter int N      = 16,
  parameter int ASID_W = 16,
  parameter int IA_W   = 48,
  parameter int OA_W   = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [IA_W-1:0]   lk_addr,
  input  logic [1:0]        lk_gcode,
  input  logic [5:0]        lk_tsz,
  input  logic [N-1:0]      e_vld,
  input  logic [ASID_W-1:0] e_asid  [N],
  input  logic [IA_W-1:0]   e_addr  [N],
  input  logic [1:0]        e_gc    [N],
  input  logic [1:0]        e_lvl   [N],
  input  logic [OA_W-1:0]   e_oaddr [N],
  input  logic [1:0]        e_perm  [N],
  output logic              lk_busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [OA_W-1:0]   rsp_oaddr,
  output logic [1:0]        rsp_perm,
  output logic [1:0]        rsp_level,
  output logic              fin_hit,
  output logic              fin_miss
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [ASID_W-1:0] q_asid;
  logic [IA_W-1:0]   q_addr;
  logic [1:0]        q_gc;
  logic [1:0]        cur_lvl;
  logic [IA_W-1:0]   pmask, paddr;
  logic [N-1:0]      hit_vec;
  logic [IDX_W-1:0]  sel;
  logic              any_hit, fin;

  assign pmask = IA_W'(blk_mask64(cur_lvl, q_gc));
  assign paddr = q_addr & ~pmask;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit_vec[i] = e_vld[i] && (e_asid[i] == q_asid) && (e_gc[i] == q_gc)
                        && (e_lvl[i] == cur_lvl) && (e_addr[i] == paddr);
  end

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_vec[i]) sel = IDX_W'(i);
  end

  assign any_hit  = |hit_vec;
  assign fin      = lk_busy && (any_hit || (cur_lvl == 2'd3));
  assign fin_hit  = fin && any_hit;
  assign fin_miss = fin && !any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_busy   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_oaddr <= '0;
      rsp_perm  <= '0;
      rsp_level <= '0;
      cur_lvl   <= '0;
    end else begin
      rsp_valid <= fin;
      if (fin) begin
        lk_busy   <= 1'b0;
        rsp_hit   <= any_hit;
        rsp_oaddr <= any_hit ? (e_oaddr[sel] | OA_W'(q_addr & pmask)) : '0;
        rsp_perm  <= any_hit ? e_perm[sel] : 2'd0;
        rsp_level <= cur_lvl;
      end else if (lk_busy) begin
        cur_lvl <= cur_lvl + 2'd1;
      end else if (lk_valid) begin
        lk_busy <= 1'b1;
        cur_lvl <= start_level(lk_tsz, lk_gcode);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid && !lk_busy) begin
      q_asid <= lk_asid;
      q_addr <= lk_addr;
      q_gc   <= lk_gcode;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N      = 16,
  parameter int ASID_W = 16,
  parameter int IA_W   = 48,
  parameter int OA_W   = 48,
  parameter int NP_W   = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [IA_W-1:0]   lk_addr,
  input  logic [1:0]        lk_gcode,
  input  logic [5:0]        lk_tsz,
  output logic              lk_busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [OA_W-1:0]   rsp_oaddr,
  output logic [1:0]        rsp_perm,
  output logic [1:0]        rsp_level,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_any_asid,
  input  logic [IA_W-1:0]   cmd_addr,
  input  logic [1:0]        cmd_gcode,
  input  logic [1:0]        cmd_level,
  input  logic [NP_W-1:0]   cmd_npages,
  input  logic [OA_W-1:0]   cmd_oaddr,
  input  logic [1:0]        cmd_perm,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  logic [N-1:0]      ent_vld;
  logic [ASID_W-1:0] ent_asid  [N];
  logic [IA_W-1:0]   ent_addr  [N];
  logic [1:0]        ent_gc    [N];
  logic [1:0]        ent_lvl   [N];
  logic [OA_W-1:0]   ent_oaddr [N];
  logic [1:0]        ent_perm  [N];
  logic              fin_hit, fin_miss;

  xlat_cache_store #(
    .N(N), .ASID_W(ASID_W), .IA_W(IA_W), .OA_W(OA_W), .NP_W(NP_W)
  ) i_store (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_asid(cmd_asid),
    .cmd_any_asid(cmd_any_asid), .cmd_addr(cmd_addr), .cmd_gcode(cmd_gcode),
    .cmd_level(cmd_level), .cmd_npages(cmd_npages), .cmd_oaddr(cmd_oaddr),
    .cmd_perm(cmd_perm),
    .e_vld(ent_vld), .e_asid(ent_asid), .e_addr(ent_addr), .e_gc(ent_gc),
    .e_lvl(ent_lvl), .e_oaddr(ent_oaddr), .e_perm(ent_perm)
  );

  xlat_cache_probe #(
    .N(N), .ASID_W(ASID_W), .IA_W(IA_W), .OA_W(OA_W)
  ) i_probe (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_addr(lk_addr),
    .lk_gcode(lk_gcode), .lk_tsz(lk_tsz),
    .e_vld(ent_vld), .e_asid(ent_asid), .e_addr(ent_addr), .e_gc(ent_gc),
    .e_lvl(ent_lvl), .e_oaddr(ent_oaddr), .e_perm(ent_perm),
    .lk_busy(lk_busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_oaddr(rsp_oaddr), .rsp_perm(rsp_perm), .rsp_level(rsp_level),
    .fin_hit(fin_hit), .fin_miss(fin_miss)
  );

  xlat_sat_counter #(.W(CNT_W)) i_hit_cnt (
    .clk(clk), .rst(rst), .inc(fin_hit), .cnt(hit_count)
  );

  xlat_sat_counter #(.W(CNT_W)) i_miss_cnt (
    .clk(clk), .rst(rst), .inc(fin_miss), .cnt(miss_count)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_cache_pkg::*;
#(
  parameter int N     = 16,
  parameter int OA_W  = 48,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [N-1:0]     ent_vld,
  input logic             lk_busy,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [OA_W-1:0]  rsp_oaddr,
  input logic [CNT_W-1:0] hit_count
);
  assert_flush_all_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_INV_ALL) |=> (ent_vld == '0));

  assert_full_insert_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_INSERT && (&ent_vld)) |=> ($countones(ent_vld) == 1));

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_until_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    lk_busy |=> (lk_busy || rsp_valid));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_oaddr == '0));

  assert_hit_step_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(hit_count) |-> (rsp_valid && rsp_hit));
endmodule

bind xlat_cache xlat_cache_chk #(.N(N), .OA_W(OA_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ent_vld(ent_vld), .lk_busy(lk_busy), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_oaddr(rsp_oaddr), .hit_count(hit_count)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int CW  = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NV  = 10;

  localparam logic [15:0] T_ASID [NV] = '{16'd1, 16'd1, 16'd1, 16'd2, 16'd2,
                                          16'd1, 16'd1, 16'd1, 16'd2, 16'd2};
  localparam logic [47:0] T_ADDR [NV] = '{48'h0000_1234_5678, 48'h0000_4023_4567,
                                          48'h0080_1234_5678, 48'h0000_6ABC_DEF0,
                                          48'h0000_1234_5678, 48'h0000_1234_5678,
                                          48'h0000_1234_5678, 48'h0000_1234_5678,
                                          48'h0000_7FFF_FFFF, 48'h0000_8000_0000};
  localparam logic [1:0]  T_GC   [NV] = '{2'd1, 2'd1, 2'd1, 2'd3, 2'd1, 2'd2, 2'd1, 2'd1, 2'd3, 2'd3};
  localparam logic [5:0]  T_TSZ  [NV] = '{6'd16, 6'd16, 6'd16, 6'd16, 6'd16,
                                          6'd16, 6'd34, 6'd25, 6'd16, 6'd16};
  localparam logic        T_HIT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [47:0] T_OA   [NV] = '{48'h0000_8000_0678, 48'h0000_0063_4567,
                                          48'h0000_D234_5678, 48'h0001_0ABC_DEF0,
                                          48'h0, 48'h0, 48'h0000_8000_0678,
                                          48'h0000_8000_0678, 48'h0001_1FFF_FFFF, 48'h0};
  localparam logic [1:0]  T_PERM [NV] = '{2'd3, 2'd1, 2'd3, 2'd2, 2'd0, 2'd0, 2'd3, 2'd3, 2'd2, 2'd0};
  localparam logic [1:0]  T_LVL  [NV] = '{2'd3, 2'd2, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd2, 2'd3};
  localparam int          T_CYC  [NV] = '{4, 3, 2, 2, 4, 4, 2, 3, 2, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [15:0] lk_asid = '0;
  logic [47:0] lk_addr = '0;
  logic [1:0]  lk_gcode = '0;
  logic [5:0]  lk_tsz = 6'd16;
  logic lk_busy, rsp_valid, rsp_hit;
  logic [47:0] rsp_oaddr;
  logic [1:0]  rsp_perm, rsp_level;
  logic cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [15:0] cmd_asid = '0;
  logic        cmd_any_asid = 1'b0;
  logic [47:0] cmd_addr = '0;
  logic [1:0]  cmd_gcode = '0;
  logic [1:0]  cmd_level = '0;
  logic [15:0] cmd_npages = '0;
  logic [47:0] cmd_oaddr = '0;
  logic [1:0]  cmd_perm = '0;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0;
  int errors = 0;
  int exp_h = 0;
  int exp_m = 0;
  bit done = 1'b0;
  logic        r_hit;
  logic [47:0] r_oa;
  logic [1:0]  r_perm, r_lvl;
  int          r_cyc;

  always #2 clk = ~clk;

  xlat_cache #(.CNT_W(CW)) i_xlat_cache (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_addr(lk_addr),
    .lk_gcode(lk_gcode), .lk_tsz(lk_tsz), .lk_busy(lk_busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_oaddr(rsp_oaddr),
    .rsp_perm(rsp_perm), .rsp_level(rsp_level),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_asid(cmd_asid),
    .cmd_any_asid(cmd_any_asid), .cmd_addr(cmd_addr), .cmd_gcode(cmd_gcode),
    .cmd_level(cmd_level), .cmd_npages(cmd_npages), .cmd_oaddr(cmd_oaddr),
    .cmd_perm(cmd_perm), .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [15:0] asid, input logic any,
                          input logic [47:0] addr, input logic [1:0] gc, input logic [1:0] lvl,
                          input logic [15:0] np, input logic [47:0] oa, input logic [1:0] perm);
    cmd_op = op; cmd_asid = asid; cmd_any_asid = any; cmd_addr = addr;
    cmd_gcode = gc; cmd_level = lvl; cmd_npages = np; cmd_oaddr = oa; cmd_perm = perm;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ins(input logic [15:0] asid, input logic [47:0] addr, input logic [1:0] gc,
                     input logic [1:0] lvl, input logic [47:0] oa, input logic [1:0] perm);
    send_cmd(2'd0, asid, 1'b0, addr, gc, lvl, 16'd0, oa, perm);
  endtask

  task automatic do_lookup(input logic [15:0] asid, input logic [47:0] addr,
                           input logic [1:0] gc, input logic [5:0] tsz, input bit exp_hit);
    lk_asid = asid; lk_addr = addr; lk_gcode = gc; lk_tsz = tsz; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    r_cyc = 0;
    do begin
      @(negedge clk);
      r_cyc++;
    end while (!rsp_valid && r_cyc < 12);
    r_hit = rsp_hit; r_oa = rsp_oaddr; r_perm = rsp_perm; r_lvl = rsp_level;
    if (exp_hit) begin if (exp_h < CMAX) exp_h++; end
    else begin if (exp_m < CMAX) exp_m++; end
  endtask

  task automatic expect_hit(input string req, input logic [47:0] oa);
    check(r_hit == 1'b1, req, "hit", 64'(r_hit), 64'd1);
    check(r_oa == oa, req, "oaddr", 64'(r_oa), 64'(oa));
  endtask

  task automatic expect_miss(input string req);
    check(r_hit == 1'b0, req, "miss", 64'(r_hit), 64'd0);
    check(r_oa == 48'd0, req, "miss oaddr", 64'(r_oa), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(lk_busy == 1'b0, "R1", "busy", 64'(lk_busy), 64'd0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(hit_count == '0 && miss_count == '0, "R1", "counters",
          64'({hit_count, miss_count}), 64'd0);
    do_lookup(16'd1, 48'h0000_1234_5678, 2'd1, 6'd16, 1'b0);
    expect_miss("R1");

    // entries for the vector table
    ins(16'd1, 48'h0000_1234_5000, 2'd1, 2'd3, 48'h0000_8000_0000, 2'd3);
    ins(16'd1, 48'h0000_4020_0000, 2'd1, 2'd2, 48'h0000_0060_0000, 2'd1);
    ins(16'd2, 48'h0000_6000_0000, 2'd3, 2'd2, 48'h0001_0000_0000, 2'd2);
    ins(16'd1, 48'h0080_0000_0000, 2'd1, 2'd1, 48'h0000_C000_0000, 2'd3);

    // R2 R3 R4: vector table
    for (int v = 0; v < NV; v++) begin
      do_lookup(T_ASID[v], T_ADDR[v], T_GC[v], T_TSZ[v], T_HIT[v]);
      check(r_cyc == T_CYC[v], "R2", $sformatf("cycles row %0d", v), 64'(r_cyc), 64'(T_CYC[v]));
      check(r_hit == T_HIT[v], "R3", $sformatf("hit row %0d", v), 64'(r_hit), 64'(T_HIT[v]));
      check(r_oa == T_OA[v], T_HIT[v] ? "R3" : "R4", $sformatf("oaddr row %0d", v),
            64'(r_oa), 64'(T_OA[v]));
      check(r_perm == T_PERM[v], T_HIT[v] ? "R3" : "R4", $sformatf("perm row %0d", v),
            64'(r_perm), 64'(T_PERM[v]));
      check(r_lvl == T_LVL[v], "R3", $sformatf("level row %0d", v), 64'(r_lvl), 64'(T_LVL[v]));
    end
    check(hit_count == CW'(exp_h), "R11", "hit count", 64'(hit_count), 64'(exp_h));
    check(miss_count == CW'(exp_m), "R11", "miss count", 64'(miss_count), 64'(exp_m));

    // R12: second request during a lookup is dropped
    begin
      int pulses = 0;
      logic [47:0] got = '0;
      lk_asid = 16'd1; lk_addr = 48'h0000_1234_5678; lk_gcode = 2'd1; lk_tsz = 6'd16;
      lk_valid = 1'b1;
      @(negedge clk);
      lk_asid = 16'd9; lk_addr = 48'h0000_4023_4567;
      @(negedge clk);
      lk_valid = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (rsp_valid) begin pulses++; got = rsp_oaddr; end
      end
      if (exp_h < CMAX) exp_h++;
      check(pulses == 1, "R12", "result pulses", 64'(pulses), 64'd1);
      check(got == 48'h0000_8000_0678, "R12", "result oaddr", 64'(got), 64'h8000_0678);
    end

    // R5: same tag overwritten, unaligned insert address aligned
    ins(16'd1, 48'h0000_1234_5FFF, 2'd1, 2'd3, 48'h0000_9000_0000, 2'd1);
    do_lookup(16'd1, 48'h0000_1234_5678, 2'd1, 6'd16, 1'b1);
    expect_hit("R5", 48'h0000_9000_0678);
    check(r_perm == 2'd1, "R5", "perm", 64'(r_perm), 64'd1);

    // R8: invalidate identifier 2
    send_cmd(2'd2, 16'd2, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0, 48'd0, 2'd0);
    do_lookup(16'd2, 48'h0000_6ABC_DEF0, 2'd3, 6'd16, 1'b0);
    expect_miss("R8");
    do_lookup(16'd1, 48'h0000_1234_5678, 2'd1, 6'd16, 1'b1);
    expect_hit("R8", 48'h0000_9000_0678);

    // R10: exact-tag removal leaves the page inside the block
    ins(16'd1, 48'h0000_4020_0000, 2'd1, 2'd3, 48'h0000_A000_0000, 2'd3);
    send_cmd(2'd3, 16'd1, 1'b0, 48'h0000_4020_0000, 2'd1, 2'd2, 16'd1, 48'd0, 2'd0);
    do_lookup(16'd1, 48'h0000_4020_0123, 2'd1, 6'd16, 1'b1);
    expect_hit("R10", 48'h0000_A000_0123);
    check(r_cyc == 4, "R10", "cycles", 64'(r_cyc), 64'd4);
    do_lookup(16'd1, 48'h0000_4030_0000, 2'd1, 6'd16, 1'b0);
    expect_miss("R10");
    // R10 fallback: hint level has no exact entry, range path removes page
    send_cmd(2'd3, 16'd1, 1'b0, 48'h0000_1234_5000, 2'd1, 2'd2, 16'd1, 48'd0, 2'd0);
    do_lookup(16'd1, 48'h0000_1234_5678, 2'd1, 6'd16, 1'b0);
    expect_miss("R10");

    // R9: range with granule code 0 (4 KB), 4 pages, any identifier
    ins(16'd3, 48'h0000_5000_3000, 2'd1, 2'd3, 48'h0000_B000_0000, 2'd3);
    ins(16'd4, 48'h0000_5000_7000, 2'd1, 2'd3, 48'h0000_C000_0000, 2'd3);
    send_cmd(2'd3, 16'd0, 1'b1, 48'h0000_5000_0000, 2'd0, 2'd0, 16'd4, 48'd0, 2'd0);
    do_lookup(16'd3, 48'h0000_5000_3010, 2'd1, 6'd16, 1'b0);
    expect_miss("R9");
    do_lookup(16'd4, 48'h0000_5000_7010, 2'd1, 6'd16, 1'b1);
    expect_hit("R9", 48'h0000_C000_0010);
    send_cmd(2'd3, 16'd5, 1'b0, 48'h0000_5000_7000, 2'd1, 2'd0, 16'd1, 48'd0, 2'd0);
    do_lookup(16'd4, 48'h0000_5000_7010, 2'd1, 6'd16, 1'b1);
    expect_hit("R9", 48'h0000_C000_0010);

    // R7: invalidate all
    send_cmd(2'd1, 16'd0, 1'b0, 48'd0, 2'd0, 2'd0, 16'd0, 48'd0, 2'd0);
    do_lookup(16'd4, 48'h0000_5000_7010, 2'd1, 6'd16, 1'b0);
    expect_miss("R7");
    do_lookup(16'd1, 48'h0080_1234_5678, 2'd1, 6'd16, 1'b0);
    expect_miss("R7");

    // R6: fill all 16 slots, then one more insert flushes
    for (int i = 0; i < 16; i++)
      ins(16'd7, 48'(i) << 12, 2'd1, 2'd3, 48'h0000_1000_0000 + (48'(i) << 12), 2'd3);
    do_lookup(16'd7, 48'h0000_0000_5010, 2'd1, 6'd16, 1'b1);
    expect_hit("R6", 48'h0000_1000_5010);
    ins(16'd7, 48'h0000_0010_0000, 2'd1, 2'd3, 48'h0000_2000_0000, 2'd1);
    do_lookup(16'd7, 48'h0000_0000_5010, 2'd1, 6'd16, 1'b0);
    expect_miss("R6");
    do_lookup(16'd7, 48'h0000_0010_0020, 2'd1, 6'd16, 1'b1);
    expect_hit("R6", 48'h0000_2000_0020);

    // R11: saturation
    for (int i = 0; i < 13; i++)
      do_lookup(16'd8, 48'h0000_0000_1000, 2'd1, 6'd16, 1'b0);
    check(miss_count == CW'(CMAX), "R11", "miss saturated", 64'(miss_count), 64'(CMAX));
    check(hit_count == CW'(exp_h), "R11", "hit count final", 64'(hit_count), 64'(exp_h));
    check(miss_count == CW'(exp_m), "R11", "miss count final", 64'(miss_count), 64'(exp_m));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule